// File: doc/BRIEF.md
# Error Statistics Counter Bank

A bank of seven saturating event counters that collect receive and transmit error statistics. Each counter has one event input and a width of its own: one 16-bit counter, four 8-bit counters and two 4-bit counters. A small register bus reads the counters and reads or writes one control word. Reading a counter returns its value and clears it. Management software can therefore poll the bank and add the returned values into wider counters that it keeps itself.

The control word has four fields. A freeze bit stops event recording, so that a set of reads shows one instant in time. A clear-all bit zeroes every counter. A single-step bit adds one to every counter as a test function. A read-only warning flag rises when any counter has filled its own warning field, which is the top few bits of that counter. Both action bits act in the cycle of the write and always read back as zero.

The bank comes out of reset frozen. Software must clear the freeze bit before events are recorded.

Top module: `err_stat_bank`

## Requirements
- R1: After reset, the control word reads 0x00000002 (freeze set), every counter reads 0, and `warn_o` is 0.
- R2: While freeze is 0, each cycle with `evt_i[k]` high adds exactly one to counter k. No other counter changes.
- R3: While freeze is 1, event pulses are dropped and the counters keep their values.
- R4: A read (`bus_en_i`=1, `bus_we_i`=0) of address k+1 (k = 0..6, in the order of `evt_i` bits) puts counter k, zero-extended, on `bus_rdata_o` after the next clock edge. The same edge clears the counter to 0.
- R5: If a read of counter k and a recorded event on counter k fall in the same cycle, the counter holds 1 afterwards.
- R6: Writing the control word (address 0) with bit 3 set adds exactly one to every counter at that edge, whatever the freeze bit holds. An event in the same cycle does not add a second increment.
- R7: Writing the control word with bit 2 set zeroes every counter at that edge. This takes priority over events and over bit 3.
- R8: Counters saturate at all ones. They never wrap.
- R9: `warn_o` is 1 exactly when some counter has every bit of its warning field at one. The warning fields are the top 8 bits of the 16-bit counter, the top 4 bits of each 8-bit counter and the top 2 bits of each 4-bit counter. So the thresholds are 0xFF00, 0xF0 and 0xC. The flag falls once those counters are cleared.
- R10: The control word reads warning in bit 0 and freeze in bit 1. Bits 2, 3 and 31:4 read 0. Only bit 1 is stored on a write, and a write to bit 0 has no effect.
- R11: Writes to counter addresses 1..7 have no effect on the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | 0 = control word, 1..7 = counters 0..6 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| evt_i | input | 7 | One event pulse per counter |
| ctrl_o | output | 32 | Current control word |
| warn_o | output | 1 | Overflow warning flag |

## Verification
The bench drives single-counter event bursts of a length that differs per counter, and then bursts on all counters at once. These tell apart counters that are cross-wired or mapped to the wrong address. It sweeps each small counter through its whole range and past saturation, and runs the 16-bit counter up to its warning threshold and past saturation. This shows where the warning flag rises for each field width, and that counters stop at all ones. Collisions are tried in the same cycle: a read with an event, a step with an event, and a clear with a step and events. These separate the load-one, increment-once and clear-first priorities. Freeze is tried with plain events and with the step bit, to show that the step bit bypasses freeze.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;
  localparam int NUM_CNT   = 7;
  localparam int CNT_W_MAX = 16;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 3;

  // Per-counter width and warning-field width (counter k is event bit k).
  localparam int CNT_W  [NUM_CNT] = '{16, 8, 8, 8, 8, 4, 4};
  localparam int WARN_W [NUM_CNT] = '{ 8, 4, 4, 4, 4, 2, 2};

  // Control word bit positions.
  localparam int CTL_WARN = 0;
  localparam int CTL_FRZ  = 1;
  localparam int CTL_CLR  = 2;
  localparam int CTL_STEP = 3;
endpackage

// File: rtl/err_stat_ctrl.sv
module err_stat_ctrl
  import err_stat_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          frz_val_i,
  input  logic          clr_val_i,
  input  logic          step_val_i,
  input  logic          warn_i,
  output logic          freeze_o,
  output logic          clr_all_o,
  output logic          step_o,
  output logic [DW-1:0] ctrl_o
);
  logic freeze_q, freeze_d, freeze_en;

  always_comb begin
    freeze_en = wr_i;
    freeze_d  = frz_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         freeze_q <= 1'b1;
    else if (freeze_en) freeze_q <= freeze_d;
  end

  // Action bits act in the cycle of the write and are never stored.
  assign clr_all_o = wr_i & clr_val_i;
  assign step_o    = wr_i & step_val_i;
  assign freeze_o  = freeze_q;

  always_comb begin
    ctrl_o           = '0;
    ctrl_o[CTL_WARN] = warn_i;
    ctrl_o[CTL_FRZ]  = freeze_q;
  end

  // R10
  frz_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> freeze_o == $past(frz_val_i));
  // R1
  frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(freeze_o));
endmodule

// File: rtl/err_stat_cnt.sv
module err_stat_cnt #(
  parameter int W  = 8,
  parameter int WW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_i,
  input  logic         freeze_i,
  input  logic         step_i,
  input  logic         clr_all_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         warn_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         inc, cnt_en;

  assign inc    = step_i | (evt_i & ~freeze_i);
  assign cnt_en = clr_all_i | rd_clr_i | inc;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_all_i)                 cnt_d = '0;
    else if (rd_clr_i)             cnt_d = inc ? ONE : '0;
    else if (inc && cnt_q != MAX)  cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign warn_o = &cnt_q[W-1 -: WW];

  // R2
  evt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !freeze_i && !step_i && !clr_all_i && !rd_clr_i && cnt_q != MAX)
      |=> cnt_o == $past(cnt_q) + ONE);
  // R3
  frz_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !step_i && !clr_all_i && !rd_clr_i) |=> $stable(cnt_o));
  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !evt_i && !step_i && !clr_all_i) |=> cnt_o == '0);
  // R5
  rd_evt_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && evt_i && !freeze_i && !clr_all_i) |=> cnt_o == ONE);
  // R7
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> cnt_o == '0);
  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX && !clr_all_i && !rd_clr_i) |=> cnt_o == MAX);
endmodule

// File: rtl/err_stat_rdport.sv
module err_stat_rdport
  import err_stat_pkg::*;
#(
  parameter int N  = NUM_CNT,
  parameter int CW = CNT_W_MAX,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   ctrl_i,
  input  logic [N*CW-1:0] cnt_flat_i,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    if (addr_i == '0) rdata_d = ctrl_i;
    for (int k = 0; k < N; k++) begin
      if (addr_i == AW'(k + 1)) rdata_d = DW'(cnt_flat_i[k*CW +: CW]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/err_stat_bank.sv
module err_stat_bank
  import err_stat_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [NUM_CNT-1:0] evt_i,
  output logic [DW-1:0] ctrl_o,
  output logic          warn_o
);
  localparam int N  = NUM_CNT;
  localparam int CW = CNT_W_MAX;

  logic            rd, wr_ctrl;
  logic            freeze, clr_all, step;
  logic [N-1:0]    warn_vec;
  logic [N*CW-1:0] cnt_flat;
  logic            unused_wdata;

  assign rd      = bus_en_i & ~bus_we_i;
  assign wr_ctrl = bus_en_i & bus_we_i & (bus_addr_i == '0);
  assign warn_o  = |warn_vec;
  assign unused_wdata = ^{bus_wdata_i[DW-1:CTL_STEP+1], bus_wdata_i[CTL_WARN]};

  err_stat_ctrl #(.DW(DW)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_ctrl),
    .frz_val_i  (bus_wdata_i[CTL_FRZ]),
    .clr_val_i  (bus_wdata_i[CTL_CLR]),
    .step_val_i (bus_wdata_i[CTL_STEP]),
    .warn_i     (warn_o),
    .freeze_o   (freeze),
    .clr_all_o  (clr_all),
    .step_o     (step),
    .ctrl_o     (ctrl_o)
  );

  for (genvar k = 0; k < N; k++) begin : g_cnt
    logic [CNT_W[k]-1:0] cnt_k;
    logic                rd_sel;

    assign rd_sel = rd & (bus_addr_i == AW'(k + 1));

    err_stat_cnt #(.W(CNT_W[k]), .WW(WARN_W[k])) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_i[k]),
      .freeze_i  (freeze),
      .step_i    (step),
      .clr_all_i (clr_all),
      .rd_clr_i  (rd_sel),
      .cnt_o     (cnt_k),
      .warn_o    (warn_vec[k])
    );

    assign cnt_flat[k*CW +: CW] = (CW)'(cnt_k);
  end

  err_stat_rdport #(.N(N), .CW(CW), .AW(AW), .DW(DW)) rdport_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_i       (rd),
    .addr_i     (bus_addr_i),
    .ctrl_i     (ctrl_o),
    .cnt_flat_i (cnt_flat),
    .rdata_o    (bus_rdata_o)
  );

  // R7, R9
  clr_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !warn_o);
  // R10
  ctrl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr_i == '0) |=>
      (bus_rdata_o[DW-1:CTL_CLR] == '0 && bus_rdata_o[CTL_FRZ] == $past(freeze)));
  // R6
  step_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr_all && !rd && g_cnt[5].cnt_k != 4'hF)
      |=> g_cnt[5].cnt_k == $past(g_cnt[5].cnt_k) + 4'd1);
endmodule

// File: tb/err_stat_bank_tb.sv
module err_stat_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 7;
  localparam int WD [N] = '{16, 8, 8, 8, 8, 4, 4};
  localparam int WF [N] = '{ 8, 4, 4, 4, 4, 2, 2};

  logic        clk, rst_n;
  logic        bus_en, bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, ctrl;
  logic [6:0]  evt;
  logic        warn;

  int n_chk, n_bad;
  bit done;
  int unsigned m_cnt [N];
  bit          m_frz;
  logic [31:0] last_exp;

  err_stat_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .evt_i(evt), .ctrl_o(ctrl), .warn_o(warn)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int unsigned cmax(int k);
    return (32'd1 << WD[k]) - 1;
  endfunction

  function automatic bit m_warn();
    bit w = 0;
    for (int k = 0; k < N; k++) begin
      int unsigned fld = m_cnt[k] >> (WD[k] - WF[k]);
      if (fld == ((32'd1 << WF[k]) - 1)) w = 1;
    end
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus/event cycle; the expected model follows the requirements.
  task automatic cyc(logic en, logic we, logic [2:0] a, logic [31:0] wd, logic [6:0] ev);
    bit step, clr, rdc, inc;
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd; evt = ev;
    step = en && we && a == 0 && wd[3];
    clr  = en && we && a == 0 && wd[2];
    rdc  = en && !we;
    if (rdc) last_exp = (a == 0) ? {30'd0, m_frz, m_warn()} : m_cnt[a-1];
    for (int k = 0; k < N; k++) begin
      inc = step || (ev[k] && !m_frz);
      if (clr) m_cnt[k] = 0;
      else if (rdc && a == 3'(k + 1)) m_cnt[k] = inc ? 1 : 0;
      else if (inc && m_cnt[k] != cmax(k)) m_cnt[k]++;
    end
    if (en && we && a == 0) m_frz = wd[1];
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0; evt = 0; bus_wdata = 0;
  endtask

  task automatic rd_lit(logic [2:0] a, string req, logic [31:0] exp);
    cyc(1, 0, a, 0, 0);
    chk(req, bus_rdata, exp);
  endtask

  task automatic rd_mdl(logic [2:0] a, string req);
    cyc(1, 0, a, 0, 0);
    chk(req, bus_rdata, last_exp);
  endtask

  task automatic pulse(logic [6:0] ev, int times);
    for (int i = 0; i < times; i++) cyc(0, 0, 0, 0, ev);
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 0; bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; evt = 0;
    m_frz = 1; for (int k = 0; k < N; k++) m_cnt[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1 warn", {31'd0, warn}, 0);
    rd_lit(0, "R1 ctrl", 32'h2);
    for (int k = 0; k < N; k++) rd_lit(3'(k + 1), "R1 cnt", 0);

    // R3 events while frozen
    pulse(7'h7F, 5);
    for (int k = 0; k < N; k++) rd_lit(3'(k + 1), "R3 frozen", 0);

    cyc(1, 1, 0, 0, 0);              // unfreeze
    rd_lit(0, "R10 ctrl unfrozen", 0);

    // R2 / R4 distinct counts per counter, mapped by address
    for (int k = 0; k < N; k++) pulse(7'(1 << k), k + 1);
    pulse(7'h7F, 3);
    for (int k = 0; k < N; k++) rd_lit(3'(k + 1), "R2 R4 count", 32'(k + 4));
    for (int k = 0; k < N; k++) rd_lit(3'(k + 1), "R4 cleared", 0);

    // R11 writes to counter address ignored
    pulse(7'h08, 2);
    cyc(1, 1, 3'd4, 32'hFF, 0);
    rd_lit(4, "R11 write ignored", 2);

    // R5 read and event same cycle
    pulse(7'h04, 4);
    cyc(1, 0, 3'd3, 0, 7'h04);
    chk("R5 read value", bus_rdata, 4);
    rd_lit(3, "R5 loaded one", 1);

    // R6 step with an event in the same cycle
    cyc(1, 1, 0, 32'h8, 7'h01);
    for (int k = 0; k < N; k++) rd_lit(3'(k + 1), "R6 step once", 1);
    rd_lit(0, "R10 action bits read 0", 0);
    // R6 step while frozen, then frozen events dropped
    cyc(1, 1, 0, 32'hA, 0);
    pulse(7'h7F, 3);
    for (int k = 0; k < N; k++) rd_lit(3'(k + 1), "R6 R3 step frozen", 1);
    cyc(1, 1, 0, 32'h1, 0);          // bit0 write ignored, unfreeze
    rd_lit(0, "R10 bit0 ignored", 0);

    // R7 clear-all over events and step
    pulse(7'h7F, 5);
    cyc(1, 1, 0, 32'hC, 7'h7F);
    for (int k = 0; k < N; k++) rd_lit(3'(k + 1), "R7 clear-all", 0);

    // R8 / R9 sweep of the small counters
    for (int k = 1; k < N; k++) begin
      for (int n = 1; n <= int'(cmax(k)) + 2; n++) begin
        pulse(7'(1 << k), 1);
        chk("R9 warn sweep", {31'd0, warn}, {31'd0, m_warn()});
      end
      rd_lit(3'(k + 1), "R8 saturate", cmax(k));
      chk("R9 warn cleared", {31'd0, warn}, 0);
    end

    // R9 warn cleared by clear-all
    pulse(7'h20, 13);
    chk("R9 warn set 4-bit", {31'd0, warn}, 1);
    rd_lit(0, "R10 ctrl warn bit", 32'h1);
    cyc(1, 1, 0, 32'h4, 0);
    chk("R7 R9 warn after clear", {31'd0, warn}, 0);

    // R8 / R9 wide counter
    pulse(7'h01, 32'hFEFF);
    chk("R9 below wide threshold", {31'd0, warn}, 0);
    pulse(7'h01, 1);
    chk("R9 at wide threshold", {31'd0, warn}, 1);
    pulse(7'h01, 300);
    rd_lit(1, "R8 wide saturate", 32'hFFFF);
    rd_mdl(1, "R4 wide cleared");
    chk("R9 wide warn cleared", {31'd0, warn}, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule